// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Generator

This block produces a pulse-width-modulated output from a symmetric triangle counter. The counter climbs one step per clock from zero to a programmable turn-around value and then descends back to zero. The output switches only when the counter equals a programmable threshold. On the rising slope that equality drives the output low. On the falling slope it drives the output high. The result is a centre-aligned pulse whose width is set by the threshold.

Several generators can share one time reference. Each instance raises a zero marker whenever its counter sits at zero, and that marker can feed the sync input of another instance. When phase loading is enabled, a sync pulse overwrites the counter with a programmable start value and direction. A follower with the same turn-around value then holds a fixed offset from its leader. The threshold is tested for equality only. If a sync load carries the counter across the threshold in one step, that edge is lost and the output keeps its old level until the next opposite-slope match. Designers who chain instances must plan for this effect.

Top module: `phased_updown_pwm`

## Requirements
- R1: While `rst` is high, and after it is released until the first counting edge, `count` is 0, `count_up` is 1 and `pwm_out` is 0.
- R2: With no sync load, `count` changes by exactly one on every clock. It rises while `count_up` is 1 and falls while `count_up` is 0. The direction turns to falling after the cycle in which `count` equals `period`, and turns to rising after the cycle in which `count` is 0. One full triangle therefore lasts 2×`period` clocks.
- R3: If `count` equals `cmp_val` while `count_up` is 1, `pwm_out` is 0 from the next clock.
- R4: If `count` equals `cmp_val` while `count_up` is 0, `pwm_out` is 1 from the next clock.
- R5: If `count` differs from `cmp_val`, `pwm_out` keeps its level on the next clock. A sync load that jumps the count across `cmp_val` therefore produces no switch.
- R6: `sync_out` is 1 in exactly the cycles in which `count` is 0, including the reset state.
- R7: When `sync_in` and `phase_en` are both 1 at a clock edge, the next `count` is `phase_val` and the next `count_up` is `phase_dir` (1 = rising, 0 = falling). This load overrides the normal step and any turn-around on that edge.
- R8: With `phase_en` at 0, `sync_in` has no effect on the count.
- R9: A follower has its `sync_in` driven by a leader's `sync_out`, with equal `period` and `phase_en` = 1. In every triangle, in the cycle after the leader's `count` is 0, the follower's `count` equals its `phase_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | CNT_W | Turn-around count of the triangle |
| cmp_val | input | CNT_W | Switching threshold |
| phase_val | input | CNT_W | Count loaded on a sync event |
| phase_en | input | 1 | Enables loading on `sync_in` |
| phase_dir | input | 1 | Direction after a load, 1 = rising |
| sync_in | input | 1 | Sync request |
| pwm_out | output | 1 | Modulated output |
| sync_out | output | 1 | High while the count is zero |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | 1 while rising, 0 while falling |

## Verification
The assertions rely on four conditions. `period` is at least one and does not change during operation. `phase_val` never exceeds `period`. Inputs are stable at each clock edge. Under these conditions the one-step rule and the turn-around checks hold on every unloaded edge. The stimulus fixes `period` at 20 for the whole run and uses only phase values 3, 5 and 10. It changes inputs on the falling clock edge. Two chained instances are compared every cycle against a behavioural model. Both the steady offset and a deliberately provoked jump across the threshold are included.

// File: rtl/pud_pkg.sv
package pud_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SET   = 2'd2
    } act_e;

    // Equality hit on the rising slope clears, on the falling slope sets.
    function automatic act_e pick_action(input logic hit, input dir_e dir);
        if (!hit)
            return ACT_HOLD;
        return (dir == DIR_UP) ? ACT_CLEAR : ACT_SET;
    endfunction

    function automatic dir_e dir_from_bit(input logic b);
        return b ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/pud_timebase.sv
module pud_timebase
    import pud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase_val,
    input  logic             phase_en,
    input  logic             phase_dir,
    input  logic             sync_in,
    output logic [CNT_W-1:0] count_q,
    output dir_e             dir_q
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
    } tb_state_t;

    tb_state_t cur, nxt;
    logic      load;

    assign load = sync_in & phase_en;

    always_comb begin
        nxt = cur;
        if (load) begin
            nxt.cnt = phase_val;
            nxt.dir = dir_from_bit(phase_dir);
        end else if (cur.dir == DIR_UP) begin
            if (cur.cnt >= period) begin
                nxt.dir = DIR_DOWN;
                nxt.cnt = cur.cnt - ONE;
            end else begin
                nxt.cnt = cur.cnt + ONE;
            end
        end else begin
            if (cur.cnt == ZERO) begin
                nxt.dir = DIR_UP;
                nxt.cnt = ONE;
            end else begin
                nxt.cnt = cur.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.cnt <= ZERO;
            cur.dir <= DIR_UP;
        end else begin
            cur <= nxt;
        end
    end

    assign count_q = cur.cnt;
    assign dir_q   = cur.dir;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((count_q == $past(count_q) + ONE) || (count_q == $past(count_q) - ONE))); // R2

    AST_PEAK_TURN: assert property (@(posedge clk) disable iff (rst)
        (!load && dir_q == DIR_UP && count_q == period) |=> (dir_q == DIR_DOWN)); // R2

    AST_ZERO_TURN: assert property (@(posedge clk) disable iff (rst)
        (!load && count_q == ZERO) |=> (dir_q == DIR_UP && count_q == ONE)); // R2

    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_q == $past(phase_val) && dir_q == dir_from_bit($past(phase_dir)))); // R7

endmodule

// File: rtl/pud_compare_action.sv
module pud_compare_action
    import pud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_q,
    input  dir_e             dir_q,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             pwm_q
);

    logic hit;
    act_e act;

    assign hit = (count_q == cmp_val);
    assign act = pick_action(hit, dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else begin
            case (act)
                ACT_CLEAR: pwm_q <= 1'b0;
                ACT_SET:   pwm_q <= 1'b1;
                default:   pwm_q <= pwm_q;
            endcase
        end
    end

    AST_UP_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
        (count_q == cmp_val && dir_q == DIR_UP) |=> !pwm_q); // R3

    AST_DOWN_MATCH_HIGH: assert property (@(posedge clk) disable iff (rst)
        (count_q == cmp_val && dir_q == DIR_DOWN) |=> pwm_q); // R4

    AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_q != cmp_val) |=> $stable(pwm_q)); // R5

endmodule

// File: rtl/pud_zero_sync.sv
module pud_zero_sync #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_q,
    output logic             sync_out
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    assign sync_out = (count_q == ZERO);

endmodule

// File: rtl/phased_updown_pwm.sv
module phased_updown_pwm
    import pud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] phase_val,
    input  logic             phase_en,
    input  logic             phase_dir,
    input  logic             sync_in,
    output logic             pwm_out,
    output logic             sync_out,
    output logic [CNT_W-1:0] count,
    output logic             count_up
);

    logic [CNT_W-1:0] cnt_w;
    dir_e             dir_w;

    pud_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .period    (period),
        .phase_val (phase_val),
        .phase_en  (phase_en),
        .phase_dir (phase_dir),
        .sync_in   (sync_in),
        .count_q   (cnt_w),
        .dir_q     (dir_w)
    );

    pud_compare_action #(.CNT_W(CNT_W)) u_action (
        .clk     (clk),
        .rst     (rst),
        .count_q (cnt_w),
        .dir_q   (dir_w),
        .cmp_val (cmp_val),
        .pwm_q   (pwm_out)
    );

    pud_zero_sync #(.CNT_W(CNT_W)) u_zero (
        .count_q  (cnt_w),
        .sync_out (sync_out)
    );

    assign count    = cnt_w;
    assign count_up = (dir_w == DIR_UP);

endmodule

// File: tb/phased_updown_pwm_tb.sv
module phased_updown_pwm_tb;

    localparam int W   = 16;
    localparam int PRD = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0] prd, cmp_a, cmp_b, ph_b;
    logic         en_b, dir_b;
    logic         pwm_a, sync_a, up_a, pwm_b, sync_b, up_b;
    logic [W-1:0] cnt_a, cnt_b;

    phased_updown_pwm #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .period(prd), .cmp_val(cmp_a),
        .phase_val('0), .phase_en(1'b0), .phase_dir(1'b1), .sync_in(1'b0),
        .pwm_out(pwm_a), .sync_out(sync_a), .count(cnt_a), .count_up(up_a)
    );

    phased_updown_pwm #(.CNT_W(W)) u_dut_peer (
        .clk(clk), .rst(rst), .period(prd), .cmp_val(cmp_b),
        .phase_val(ph_b), .phase_en(en_b), .phase_dir(dir_b), .sync_in(sync_a),
        .pwm_out(pwm_b), .sync_out(sync_b), .count(cnt_b), .count_up(up_b)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit cmp_on = 0;

    // reference model state
    int ma_c = 0, ma_u = 1, ma_p = 0;
    int mb_c = 0, mb_u = 1, mb_p = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(inout int c, inout int u, inout int p, input bit ld,
                        input int ph, input int pd, input int pr, input int cm);
        int oc, ou;
        oc = c;
        ou = u;
        if (oc == cm) p = (ou != 0) ? 0 : 1;
        if (ld) begin
            c = ph;
            u = pd;
        end else if (ou != 0) begin
            if (oc >= pr) begin u = 0; c = oc - 1; end
            else c = oc + 1;
        end else begin
            if (oc == 0) begin u = 1; c = 1; end
            else c = oc - 1;
        end
    endtask

    always @(posedge clk) begin
        bit ld_b;
        cyc++;
        if (rst) begin
            ma_c = 0; ma_u = 1; ma_p = 0;
            mb_c = 0; mb_u = 1; mb_p = 0;
        end else begin
            ld_b = (ma_c == 0) && en_b;
            step(ma_c, ma_u, ma_p, 1'b0, 0, 1, int'(prd), int'(cmp_a));
            step(mb_c, mb_u, mb_p, ld_b, int'(ph_b), int'(dir_b), int'(prd), int'(cmp_b));
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(cnt_a) == ma_c, "R2 count A", int'(cnt_a), ma_c);
            check(int'(up_a) == ma_u, "R2 dir A", int'(up_a), ma_u);
            check(int'(pwm_a) == ma_p, "R3/R4 pwm A", int'(pwm_a), ma_p);
            check(int'(sync_a) == int'(ma_c == 0), "R6 sync A", int'(sync_a), int'(ma_c == 0));
            check(int'(cnt_b) == mb_c, "R7 count B", int'(cnt_b), mb_c);
            check(int'(up_b) == mb_u, "R7 dir B", int'(up_b), mb_u);
            check(int'(pwm_b) == mb_p, "R5 pwm B", int'(pwm_b), mb_p);
            check(int'(sync_b) == int'(mb_c == 0), "R6 sync B", int'(sync_b), int'(mb_c == 0));
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // advance to the first negedge just after leader leaves zero
    task automatic wait_a_rise1();
        int n = 0;
        @(negedge clk);
        while (!(cnt_a == 1 && up_a == 1'b1) && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) check(1'b0, "R2 leader stuck", int'(cnt_a), 1);
    endtask

    task automatic wait_b(input int v);
        int n = 0;
        @(negedge clk);
        while (!(int'(cnt_b) == v && up_b == 1'b1) && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) check(1'b0, "R2 follower stuck", int'(cnt_b), v);
    endtask

    initial begin
        int t0;
        prd   = W'(PRD);
        cmp_a = W'(8);
        cmp_b = W'(6);
        ph_b  = W'(10);
        en_b  = 1'b1;
        dir_b = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cnt_a == 0 && cnt_b == 0, "R1 count in reset", int'(cnt_a), 0);
        check(up_a && up_b, "R1 direction in reset", int'(up_a), 1);
        check(!pwm_a && !pwm_b, "R1 pwm in reset", int'(pwm_a), 0);
        check(sync_a, "R6 sync in reset", int'(sync_a), 1);
        rst = 1'b0;
        cmp_on = 1;

        // R2: triangle length
        repeat (30) @(negedge clk);
        while (!sync_a) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!sync_a) @(negedge clk);
        check(cyc - t0 == 2 * PRD, "R2 triangle length", cyc - t0, 2 * PRD);

        // R9: stable offset over several triangles
        for (int i = 0; i < 3; i++) begin
            wait_a_rise1();
            check(int'(cnt_b) == 10 && up_b, "R9 follower offset", int'(cnt_b), 10);
        end

        // steady at phase 5: rising match at 6 happens normally (R3)
        wait_a_rise1();
        ph_b = W'(5);
        for (int i = 0; i < 3; i++) wait_a_rise1();
        check(int'(cnt_b) == 5, "R9 follower offset 5", int'(cnt_b), 5);
        wait_b(15);
        check(pwm_b == 1'b0, "R3 low after rising match", int'(pwm_b), 0);

        // R5: jump from 4 to 10 skips the threshold 6
        wait_a_rise1();
        ph_b = W'(10);
        wait_a_rise1();
        check(int'(cnt_b) == 10, "R7 load across threshold", int'(cnt_b), 10);
        check(pwm_b == 1'b1, "R5 no switch on jump", int'(pwm_b), 1);
        wait_b(15);
        check(pwm_b == 1'b1, "R5 output held after skipped match", int'(pwm_b), 1);
        wait_a_rise1();
        check(int'(cnt_b) == 10, "R9 offset restored", int'(cnt_b), 10);
        wait_b(15);
        check(pwm_b == 1'b0, "R3 next rising match", int'(pwm_b), 0);

        // R8: loading disabled, follower keeps running
        wait_a_rise1();
        en_b = 1'b0;
        ph_b = W'(3);
        wait_a_rise1();
        check(int'(cnt_b) == 10, "R8 sync ignored", int'(cnt_b), 10);

        // R7: load with falling direction
        en_b  = 1'b1;
        ph_b  = W'(10);
        dir_b = 1'b0;
        wait_a_rise1();
        check(int'(cnt_b) == 10 && !up_b, "R7 falling load", int'(up_b), 0);
        repeat (90) @(negedge clk);

        // R3/R4 boundary thresholds at zero and at the peak
        cmp_a = W'(0);
        repeat (90) @(negedge clk);
        check(pwm_a == 1'b1, "R4 threshold zero", int'(pwm_a), 1);
        cmp_a = W'(PRD);
        repeat (90) @(negedge clk);
        check(pwm_a == 1'b0, "R3 threshold at peak", int'(pwm_a), 0);

        // R1: reset during operation
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(cnt_a == 0 && cnt_b == 0, "R1 count after mid reset", int'(cnt_b), 0);
        check(up_a && up_b && !pwm_a && !pwm_b, "R1 state after mid reset", int'(pwm_b), 0);
        rst = 1'b0;
        repeat (100) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule